// File: doc/BRIEF.md
# Private Interrupt Priority Selector

This block picks the most urgent interrupt among the 32 private lines that belong to one processor. It then weighs that winner against one candidate that arrives from a separate message-interrupt path. The caller presents four things: the qualified pending vector, one 8-bit priority for each line, a 2-bit group for each line, and the best candidate known so far. A one-cycle `start` pulse begins the work. The block latches the pending vector and the starting best. It then visits the lines in index order, one line per clock, and keeps the winner in registers.

After the scan, one merge cycle compares the external candidate. This happens only when both its enables are set and its priority is not the idle value 0xFF. A single-cycle `done` pulse then shows that the result outputs are valid. When nothing better was found but the best at start was valid and fell in one of this block's ID ranges, the block raises `rescanReq`. That flag tells the surrounding logic that its cached best has gone stale and a full rescan is needed. A lower priority number means more urgent.

Top module: `pvt_irq_picker`

## Requirements
- R1: A synchronous reset sets `bestPrio` to 0xFF and `bestId` to 0, and clears `bestGrp`, `betterFound`, `rescanReq`, `done` and `busy`.
- R2: A `start` pulse accepted while idle loads the current candidate as the best. When the pending vector is non-zero, the block takes 32 scan clocks plus one merge clock, and `done` is high in the cycle after the 33rd rising edge that follows the accepting edge. When the pending vector is zero, the scan is skipped and `done` follows the very next edge. `done` is high for exactly one cycle.
- R3: A pending line replaces the best when its priority value is numerically lower than the best priority.
- R4: On equal priority, a candidate replaces the best when its ID is less than or equal to the best ID. This rule applies to private lines, whose ID is their index 0..31, and to the external candidate.
- R5: A line whose bit in the pending vector is 0 never changes the result, whatever its priority.
- R6: The external candidate is never merged when its priority is 0xFF.
- R7: When a private line wins, the result group is that line's 2-bit group field. When nothing wins, the starting group is kept.
- R8: The external candidate is compared only when `extLocalEn` and `extGlobalEn` are both 1. If it wins, its ID, priority and group replace the best.
- R9: `betterFound` is 1 at `done` exactly when a private line or the external candidate replaced the starting best.
- R10: `rescanReq` is 1 at `done` exactly when `betterFound` is 0, the starting priority is not 0xFF, and the starting ID is below 32 or at least `MSG_BASE` (default 8192).
- R11: A `start` pulse that arrives while `busy` is 1 is ignored. The run in progress keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a selection pass (ignored while busy) |
| pendVec | input | 32 | Qualified pending bit per private line, latched at start |
| prioFlat | input | 256 | Priority of line i at bits [8i+7:8i] |
| groupFlat | input | 64 | Group of line i at bits [2i+1:2i] |
| curId | input | 16 | ID of the best candidate so far |
| curPrio | input | 8 | Priority of the best candidate so far |
| curGrp | input | 2 | Group of the best candidate so far |
| extId | input | 16 | External message-interrupt candidate ID |
| extPrio | input | 8 | External candidate priority |
| extGrp | input | 2 | External candidate group |
| extLocalEn | input | 1 | Per-processor enable for the external candidate |
| extGlobalEn | input | 1 | Global enable for the external candidate |
| bestId | output | 16 | Selected ID |
| bestPrio | output | 8 | Selected priority |
| bestGrp | output | 2 | Selected group |
| betterFound | output | 1 | The starting best was replaced |
| rescanReq | output | 1 | A full rescan is needed |
| done | output | 1 | One-cycle pulse: result valid |
| busy | output | 1 | A pass is in progress |

## Verification
A wrong scan index or a lost pending latch shows up as a wrong `bestId` or `bestPrio` at the very next `done`. The `done` pulse itself comes 33 cycles or 1 cycle after start, so an off-by-one in the counter moves that pulse and is caught on the first pass. A wrong tie comparison changes the result only when priorities are equal. For that reason, the random priorities are drawn from a narrow set so that ties happen often. A stale found flag or a stale copy of the starting best shows up as a wrong `rescanReq` on the pass where it matters.

// File: rtl/pick_pkg.sv
package pick_pkg;
  localparam int NUM_LINES = 32;
  localparam int PRIO_W = 8;
  localparam int GRP_W = 2;
  localparam int ID_W = 16;
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

  typedef struct packed {
    logic load;   // latch start state
    logic scan;   // evaluate line at idx
    logic merge;  // external compare, finish
  } strobe_t;
endpackage

// File: rtl/pick_ctrl.sv
module pick_ctrl
  import pick_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pendZero,
  output strobe_t          stb,
  output logic [IDX_W-1:0] idx,
  output logic             busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_MERGE} state_t;
  state_t state;

  always_comb begin
    stb.load  = start && (state == ST_IDLE);
    stb.scan  = (state == ST_SCAN);
    stb.merge = (state == ST_MERGE);
    busy      = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (stb.load) begin
          idx   <= '0;
          state <= pendZero ? ST_MERGE : ST_SCAN;
        end
        ST_SCAN: begin
          if (idx == IDX_W'(NUM_LINES - 1)) state <= ST_MERGE;
          idx <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pick_dp.sv
module pick_dp
  import pick_pkg::*;
#(
  parameter int MSG_BASE = 8192
) (
  input  logic                        clk,
  input  logic                        rst,
  input  strobe_t                     stb,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NUM_LINES-1:0]        pendVec,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  input  logic [NUM_LINES*GRP_W-1:0]  groupFlat,
  input  logic [ID_W-1:0]             curId,
  input  logic [PRIO_W-1:0]           curPrio,
  input  logic [GRP_W-1:0]            curGrp,
  input  logic [ID_W-1:0]             extId,
  input  logic [PRIO_W-1:0]           extPrio,
  input  logic [GRP_W-1:0]            extGrp,
  input  logic                        extLocalEn,
  input  logic                        extGlobalEn,
  output logic [ID_W-1:0]             bestId,
  output logic [PRIO_W-1:0]           bestPrio,
  output logic [GRP_W-1:0]            bestGrp,
  output logic                        betterFound,
  output logic                        rescanReq,
  output logic                        done
);
  logic [NUM_LINES-1:0] pendLat;
  logic [ID_W-1:0]      initId;
  logic [PRIO_W-1:0]    initPrio;

  logic [PRIO_W-1:0] linePrio [NUM_LINES];
  logic [GRP_W-1:0]  lineGrp  [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_unpack
    assign linePrio[g] = prioFlat[g*PRIO_W +: PRIO_W];
    assign lineGrp[g]  = groupFlat[g*GRP_W +: GRP_W];
  end

  function automatic logic beats(input logic [PRIO_W-1:0] p, input logic [ID_W-1:0] id,
                                 input logic [PRIO_W-1:0] refP, input logic [ID_W-1:0] refId);
    return (p < refP) || ((p == refP) && (id <= refId));
  endfunction

  logic [ID_W-1:0] lineId;
  logic lineWin, extWin, extFound, initInRange;

  always_comb begin
    lineId      = ID_W'(idx);
    lineWin     = pendLat[idx] && beats(linePrio[idx], lineId, bestPrio, bestId);
    extWin      = extLocalEn && extGlobalEn && (extPrio != IDLE_PRIO) &&
                  beats(extPrio, extId, bestPrio, bestId);
    extFound    = betterFound || extWin;
    initInRange = (initId < ID_W'(NUM_LINES)) || (32'(initId) >= MSG_BASE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendLat     <= '0;
      initId      <= '0;
      initPrio    <= IDLE_PRIO;
      bestId      <= '0;
      bestPrio    <= IDLE_PRIO;
      bestGrp     <= '0;
      betterFound <= 1'b0;
      rescanReq   <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= stb.merge;
      if (stb.load) begin
        pendLat     <= pendVec;
        initId      <= curId;
        initPrio    <= curPrio;
        bestId      <= curId;
        bestPrio    <= curPrio;
        bestGrp     <= curGrp;
        betterFound <= 1'b0;
        rescanReq   <= 1'b0;
      end
      if (stb.scan && lineWin) begin
        bestId      <= lineId;
        bestPrio    <= linePrio[idx];
        bestGrp     <= lineGrp[idx];
        betterFound <= 1'b1;
      end
      if (stb.merge) begin
        if (extWin) begin
          bestId   <= extId;
          bestPrio <= extPrio;
          bestGrp  <= extGrp;
        end
        betterFound <= extFound;
        rescanReq   <= !extFound && (initPrio != IDLE_PRIO) && initInRange;
      end
    end
  end
endmodule

// File: rtl/pvt_irq_picker.sv
module pvt_irq_picker
  import pick_pkg::*;
#(
  parameter int MSG_BASE = 8192
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [NUM_LINES-1:0]        pendVec,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  input  logic [NUM_LINES*GRP_W-1:0]  groupFlat,
  input  logic [ID_W-1:0]             curId,
  input  logic [PRIO_W-1:0]           curPrio,
  input  logic [GRP_W-1:0]            curGrp,
  input  logic [ID_W-1:0]             extId,
  input  logic [PRIO_W-1:0]           extPrio,
  input  logic [GRP_W-1:0]            extGrp,
  input  logic                        extLocalEn,
  input  logic                        extGlobalEn,
  output logic [ID_W-1:0]             bestId,
  output logic [PRIO_W-1:0]           bestPrio,
  output logic [GRP_W-1:0]            bestGrp,
  output logic                        betterFound,
  output logic                        rescanReq,
  output logic                        done,
  output logic                        busy
);
  strobe_t          stb;
  logic [IDX_W-1:0] idx;

  pick_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .pendZero(pendVec == '0),
    .stb(stb), .idx(idx), .busy(busy)
  );

  pick_dp #(.MSG_BASE(MSG_BASE)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .idx(idx),
    .pendVec(pendVec), .prioFlat(prioFlat), .groupFlat(groupFlat),
    .curId(curId), .curPrio(curPrio), .curGrp(curGrp),
    .extId(extId), .extPrio(extPrio), .extGrp(extGrp),
    .extLocalEn(extLocalEn), .extGlobalEn(extGlobalEn),
    .bestId(bestId), .bestPrio(bestPrio), .bestGrp(bestGrp),
    .betterFound(betterFound), .rescanReq(rescanReq), .done(done)
  );
endmodule

// File: rtl/pvt_irq_picker_chk.sv
module pvt_irq_picker_chk
  import pick_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input strobe_t           stb,
  input logic              busy,
  input logic              done,
  input logic              betterFound,
  input logic              rescanReq,
  input logic [PRIO_W-1:0] bestPrio,
  input logic [PRIO_W-1:0] extPrio,
  input logic              extLocalEn,
  input logic              extGlobalEn
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
  AST_DONE_ENDS_PASS: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R2
  AST_SCAN_NO_WORSE: assert property (@(posedge clk) disable iff (rst)
    $past(stb.scan) |-> (bestPrio <= $past(bestPrio))); // R3
  AST_SCAN_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    ($past(stb.scan) && (bestPrio != $past(bestPrio))) |-> betterFound); // R9
  AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst)
    ($past(stb.merge) && !($past(extLocalEn) && $past(extGlobalEn))) |->
      (bestPrio == $past(bestPrio))); // R8
  AST_EXT_IDLE_PRIO: assert property (@(posedge clk) disable iff (rst)
    ($past(stb.merge) && ($past(extPrio) == IDLE_PRIO)) |->
      (bestPrio == $past(bestPrio))); // R6
  AST_RESCAN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (done && rescanReq) |-> !betterFound); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |-> !stb.load); // R11
endmodule

bind pvt_irq_picker pvt_irq_picker_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .stb(stb), .busy(busy), .done(done),
  .betterFound(betterFound), .rescanReq(rescanReq), .bestPrio(bestPrio),
  .extPrio(extPrio), .extLocalEn(extLocalEn), .extGlobalEn(extGlobalEn)
);

// File: tb/pvt_irq_picker_bench.sv
`timescale 1ns/1ps
module pvt_irq_picker_bench;
  logic clk = 0, rst = 1, start = 0;
  logic [31:0]  pendVec = '0;
  logic [255:0] prioFlat = '1;
  logic [63:0]  groupFlat = '0;
  logic [15:0]  curId = '0, extId = '0;
  logic [7:0]   curPrio = 8'hFF, extPrio = 8'hFF;
  logic [1:0]   curGrp = '0, extGrp = '0;
  logic extLocalEn = 0, extGlobalEn = 0;
  logic [15:0] bestId;
  logic [7:0]  bestPrio;
  logic [1:0]  bestGrp;
  logic betterFound, rescanReq, done, busy;

  int checks = 0, fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pvt_irq_picker u_pvt_irq_picker (.*);

  typedef struct packed {
    logic [15:0] id; logic [7:0] prio; logic [1:0] grp; logic found; logic rescan;
  } res_t;

  function automatic logic better(input logic [7:0] p, input logic [15:0] id,
                                  input logic [7:0] rp, input logic [15:0] rid);
    return (p < rp) || (p == rp && id <= rid);
  endfunction

  function automatic res_t model();
    res_t r;
    r.id = curId; r.prio = curPrio; r.grp = curGrp; r.found = 0;
    for (int i = 0; i < 32; i++)
      if (pendVec[i] && better(prioFlat[i*8 +: 8], 16'(i), r.prio, r.id)) begin
        r.id = 16'(i); r.prio = prioFlat[i*8 +: 8]; r.grp = groupFlat[i*2 +: 2]; r.found = 1;
      end
    if (extLocalEn && extGlobalEn && extPrio != 8'hFF && better(extPrio, extId, r.prio, r.id)) begin
      r.id = extId; r.prio = extPrio; r.grp = extGrp; r.found = 1;
    end
    r.rescan = !r.found && curPrio != 8'hFF && (curId < 32 || curId >= 8192);
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Run one pass; optionally pulse start again mid-pass with altered cur values (R11).
  task automatic runPass(input string tag, input bit poke);
    res_t e;
    int n;
    int expLat;
    e = model();
    expLat = (pendVec == 0) ? 1 : 33;
    start = 1;
    @(posedge clk); #1 start = 0;
    n = 0;
    for (int k = 1; k <= 40; k++) begin
      if (poke && k == 5 && busy) begin
        curId = 16'd1; curPrio = 8'h00; start = 1;
      end
      @(posedge clk); #1 start = 0;
      if (done) begin n = k; break; end
    end
    check(n == expLat, "R2", {tag, " latency"}, n, expLat);
    check(bestId == e.id, "R3/R4", {tag, " bestId"}, bestId, e.id);
    check(bestPrio == e.prio, "R3/R8", {tag, " bestPrio"}, bestPrio, e.prio);
    check(bestGrp == e.grp, "R7", {tag, " bestGrp"}, bestGrp, e.grp);
    check(betterFound == e.found, "R9", {tag, " betterFound"}, betterFound, e.found);
    check(rescanReq == e.rescan, "R10", {tag, " rescanReq"}, rescanReq, e.rescan);
    @(posedge clk); #1;
    check(!done, "R2", {tag, " done width"}, done, 0);
  endtask

  task automatic clearAll();
    pendVec = '0; prioFlat = '1; groupFlat = '0;
    curId = 16'd100; curPrio = 8'hFF; curGrp = 2'd0;
    extId = 16'd9000; extPrio = 8'hFF; extGrp = 2'd0; extLocalEn = 0; extGlobalEn = 0;
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin @(posedge clk); cycles++; end
    check(0, "WDOG", "timeout", cycles, 200000);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd7531));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(bestPrio == 8'hFF, "R1", "reset bestPrio", bestPrio, 255);
    check(bestId == 0, "R1", "reset bestId", bestId, 0);
    check(!betterFound && !rescanReq && !done && !busy, "R1", "reset flags",
          {betterFound, rescanReq, done, busy}, 0);
    @(posedge clk); #1;

    // R2: empty vector skips scan
    clearAll(); runPass("R2 empty", 0);
    // R3: lower priority wins
    clearAll(); pendVec = 32'h0000_0410; prioFlat[4*8 +: 8] = 8'h40; prioFlat[10*8 +: 8] = 8'h20;
    groupFlat[10*2 +: 2] = 2'd3; runPass("R3 lower", 0);
    check(bestId == 10 && bestGrp == 3, "R7", "group of winner", bestGrp, 3);
    // R4: tie goes to lower index; line 7 tie with curId 7 wins, line 8 does not
    clearAll(); curId = 16'd7; curPrio = 8'h30; pendVec = 32'h0000_0180;
    prioFlat[7*8 +: 8] = 8'h30; prioFlat[8*8 +: 8] = 8'h30; runPass("R4 tie", 0);
    check(bestId == 7 && betterFound, "R4", "tie equal id wins", bestId, 7);
    // R5: unpended urgent line ignored
    clearAll(); curPrio = 8'h50; pendVec = 32'h0000_0001; prioFlat[0 +: 8] = 8'h60;
    prioFlat[3*8 +: 8] = 8'h00; runPass("R5 masked", 0);
    check(bestPrio == 8'h50, "R5", "unpended line no effect", bestPrio, 8'h50);
    // R6: external at 0xFF never merged
    clearAll(); extLocalEn = 1; extGlobalEn = 1; extId = 16'd0; runPass("R6 ext idle", 0);
    check(!betterFound, "R6", "ext idle prio", betterFound, 0);
    // R8: only one enable -> ignored; both -> merged
    clearAll(); curPrio = 8'h80; extPrio = 8'h10; extGrp = 2'd2; extLocalEn = 1; runPass("R8 half", 0);
    check(bestPrio == 8'h80, "R8", "ext one enable", bestPrio, 8'h80);
    extGlobalEn = 1; runPass("R8 both", 0);
    check(bestId == 16'd9000 && bestGrp == 2, "R8", "ext merged", bestId, 9000);
    // R10: rescan for in-range valid start with nothing better
    clearAll(); curId = 16'd5; curPrio = 8'h10; pendVec = 32'h1; prioFlat[0 +: 8] = 8'h20;
    runPass("R10 low", 0);
    check(rescanReq, "R10", "rescan low range", rescanReq, 1);
    curId = 16'd500; runPass("R10 mid", 0);
    check(!rescanReq, "R10", "no rescan mid range", rescanReq, 0);
    curId = 16'd8192; runPass("R10 msg", 0);
    // R11: start during busy ignored
    clearAll(); curId = 16'd40; curPrio = 8'h90; pendVec = 32'h8000_0002;
    prioFlat[1*8 +: 8] = 8'h91; prioFlat[31*8 +: 8] = 8'h70; runPass("R11 poke", 1);
    check(bestId == 31, "R11", "restart ignored", bestId, 31);

    // Random passes with narrow priorities to force ties
    for (int t = 0; t < 250; t++) begin
      clearAll();
      pendVec = ($urandom % 5 == 0) ? 32'h0 : $urandom & $urandom;
      for (int i = 0; i < 32; i++) begin
        prioFlat[i*8 +: 8] = ($urandom % 6 == 0) ? 8'hFF : 8'($urandom % 6) << 4;
        groupFlat[i*2 +: 2] = 2'($urandom);
      end
      curId = ($urandom % 3 == 0) ? 16'($urandom % 40) : (($urandom % 2) ? 16'(8192 + $urandom % 8) : 16'(100));
      curPrio = ($urandom % 5 == 0) ? 8'hFF : 8'($urandom % 6) << 4;
      curGrp = 2'($urandom);
      extId = 16'($urandom % 9000);
      extPrio = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 6) << 4;
      extGrp = 2'($urandom);
      extLocalEn = 1'($urandom); extGlobalEn = 1'($urandom);
      runPass("rand", ($urandom % 8) == 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule